// File: doc/BRIEF.md
# External Interrupt Sense Detector

This block watches one dedicated external pin and turns selected activity on it into an interrupt request. A 2-bit sense selection picks one of four conditions: the pin sitting low, any change of level, a high-to-low transition or a low-to-high transition. The pin is first brought into the clock domain through a synchroniser. Each synchronised sample is then compared with the one before it to find transitions.

In the three transition modes a detected event sets a sticky flag. The request is the flag gated by the enable. Software clears the flag with a one-cycle clear strobe, or the interrupt controller clears it with an acknowledge strobe when it takes the vector. In the low-level mode no flag is kept. The request simply follows the synchronised low level, gated by the enable, for as long as the pin stays low.

The detector looks only at the pin level. It does not know the pin's direction, so a pin that software drives as an output still raises the interrupt. This gives software a way to trigger the interrupt itself. The pin, sense, enable and strobe inputs are plain control signals with no handshake.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is held and after it is released, with the pin high, irq_req_o and flag_o are 0. The synchroniser and previous-sample stages reset to the high level, so a high pin produces no event after reset.
- R2: A pin change made between clock edges N and N+1 is captured by the first synchroniser stage at edge N+1 and becomes an event after edge N+2. The flag reads 1 only after edge N+3, and no earlier. The flag can rise only if the sense mode in the previous cycle was not low-level.
- R3: With sense_mode_i = 2'b11 (rising), only a 0-to-1 change of the synchronised pin sets the flag. A 1-to-0 change leaves the flag at 0.
- R4: With sense_mode_i = 2'b10 (falling), only a 1-to-0 change sets the flag. A 0-to-1 change leaves the flag at 0.
- R5: With sense_mode_i = 2'b01 (any change), both a 0-to-1 and a 1-to-0 change set the flag.
- R6: With sense_mode_i = 2'b00 (low level), irq_req_o is 1 exactly while irq_en_i is 1 and the synchronised pin is 0. The request follows a pin change after the second edge. In this mode the flag is cleared on the next edge and is never set.
- R7: In the three transition modes irq_req_o equals irq_en_i AND flag_o. The flag still sets while irq_en_i is 0. Raising irq_en_i then asserts the request in the same cycle. With irq_en_i at 0 the request is never asserted in any mode.
- R8: A one-cycle pulse on flag_clr_i or on irq_ack_i clears the flag at the next edge when no event occurs in that cycle.
- R9: When an event and a clear (or acknowledge) strobe fall in the same cycle, the flag is 1 after that edge.
- R10: A pin pulse that lasts exactly one clock period is detected in the transition modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw level of the external pin, asynchronous |
| sense_mode_i | input | 2 | 00 low level, 01 any change, 10 falling, 11 rising |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| irq_ack_i | input | 1 | Vector acknowledge strobe, clears the flag |
| irq_req_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Latched event flag, transition modes only |

## Verification
The assertions check the flag priorities on every cycle:
- An event always leaves the flag set.
- A lone clear or acknowledge always leaves it clear.
- Low-level mode always empties it.
- The flag never rises out of low-level mode.
- A disabled request is never asserted.

The exact latency through the synchroniser and the edge register cannot be seen by these local properties, so only the bench's scenarios show it. The same holds for which direction of change each mode accepts, for detection of a one-period pulse, and for a request appearing as soon as the enable rises on an already latched flag.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int SENSE_W = 2;

  // Encoding is visible at the sense_mode_i port.
  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES      = 2,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);

  localparam int LAST = STAGES - 1;

  logic stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RESET_LEVEL;
          else        stage_q[i] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RESET_LEVEL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign level_o = stage_q[LAST];

endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  output edge_evt_t evt_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_LEVEL;
    else        prev_q <= level_i;
  end

  always_comb begin
    evt_o.rise = level_i & ~prev_q;
    evt_o.fall = ~level_i & prev_q;
  end

endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_clr_i,
  output logic flag_o
);

  logic flag_q;

  // Priority: mode hold-clear, then set, then strobe clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (hold_clr_i) flag_q <= 1'b0;
    else if (set_i)      flag_q <= 1'b1;
    else if (clr_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !hold_clr_i) |=> flag_o);

  // R8
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R6
  low_mode_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |=> !flag_o);

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sense_mode_i,
  input  logic       irq_en_i,
  input  logic       flag_clr_i,
  input  logic       irq_ack_i,
  output logic       irq_req_o,
  output logic       flag_o
);

  sense_mode_e mode;
  logic        level;
  edge_evt_t   evt;
  logic        evt_hit;
  logic        low_mode;

  assign mode     = sense_mode_e'(sense_mode_i);
  assign low_mode = (mode == SENSE_LOW);

  ext_irq_sync #(
    .STAGES      (SYNC_STAGES),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .level_o (level)
  );

  ext_irq_edge #(
    .RESET_LEVEL (RESET_LEVEL)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level),
    .evt_o   (evt)
  );

  always_comb begin
    unique case (mode)
      SENSE_ANY:  evt_hit = evt.rise | evt.fall;
      SENSE_FALL: evt_hit = evt.fall;
      SENSE_RISE: evt_hit = evt.rise;
      default:    evt_hit = 1'b0;
    endcase
  end

  ext_irq_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_hit),
    .clr_i      (flag_clr_i | irq_ack_i),
    .hold_clr_i (low_mode),
    .flag_o     (flag_o)
  );

  always_comb begin
    if (low_mode) irq_req_o = irq_en_i & ~level;
    else          irq_req_o = irq_en_i & flag_o;
  end

  // R2
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(sense_mode_i != 2'b00));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_req_o);

endmodule

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;

  localparam time CLK_HALF = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic [1:0] mode = 2'b11;
  logic       en = 1'b1;
  logic       clr = 1'b0;
  logic       ack = 1'b0;
  logic       req;
  logic       flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    req;
    bit    flag;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;

  always #(CLK_HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_irq_detect u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin),
    .sense_mode_i (mode),
    .irq_en_i     (en),
    .flag_clr_i   (clr),
    .irq_ack_i    (ack),
    .irq_req_o    (req),
    .flag_o       (flag)
  );

  task automatic expect_at(input int off, input bit r, input bit f, input string tag);
    exp_t e;
    e.at = cyc + off;
    e.req = r;
    e.flag = f;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(1);
  endtask

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      cur = sbq.pop_front();
      checks++;
      if (cur.at < cyc) begin
        errors++;
        $display("FAIL %s: expectation for cycle %0d was missed (now %0d)", cur.tag, cur.at, cyc);
      end else if (req !== cur.req || flag !== cur.flag) begin
        errors++;
        $display("FAIL %s: cycle %0d req=%b flag=%b, expected req=%b flag=%b",
                 cur.tag, cyc, req, flag, cur.req, cur.flag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 20000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state with the pin idle high
    step(3);
    expect_at(0, 0, 0, "R1 in reset");
    step(1);
    rst_n = 1'b1;
    expect_at(0, 0, 0, "R1 after release");
    expect_at(3, 0, 0, "R1 no event from idle pin");
    step(5);

    // R3: rising mode 11
    pin = 1'b0;
    expect_at(3, 0, 0, "R3 fall ignored");
    step(5);
    pin = 1'b1;
    expect_at(2, 0, 0, "R2 not before third edge");
    expect_at(3, 1, 1, "R3 rise sets flag");
    step(5);

    // R8: clear strobe
    clr = 1'b1;
    expect_at(1, 0, 0, "R8 clear strobe");
    step(1);
    clr = 1'b0;
    step(2);

    // R4: falling mode 10
    mode = 2'b10;
    pin = 1'b0;
    expect_at(3, 1, 1, "R4 fall sets flag");
    step(5);
    ack = 1'b1;
    expect_at(1, 0, 0, "R8 acknowledge clears");
    step(1);
    ack = 1'b0;
    pin = 1'b1;
    expect_at(3, 0, 0, "R4 rise ignored");
    step(5);

    // R5: any-change mode 01
    mode = 2'b01;
    pin = 1'b0;
    expect_at(3, 1, 1, "R5 fall detected");
    step(5);
    pulse_clear();
    pin = 1'b1;
    expect_at(3, 1, 1, "R5 rise detected");
    step(5);
    pulse_clear();

    // R7: enable gates the request, not the flag
    en = 1'b0;
    pin = 1'b0;
    expect_at(3, 0, 1, "R7 flag set while disabled");
    step(5);
    en = 1'b1;
    expect_at(0, 1, 1, "R7 enable raises request");
    step(1);
    pulse_clear();

    // R10: one-period pulse in rising mode
    mode = 2'b11;
    pin = 1'b1;
    step(1);
    pin = 1'b0;
    expect_at(2, 1, 1, "R10 one-period pulse");
    step(5);
    pulse_clear();

    // R9: event and clear in the same cycle
    pin = 1'b1;
    step(2);
    clr = 1'b1;
    expect_at(1, 1, 1, "R9 set wins over clear");
    step(1);
    clr = 1'b0;
    step(2);

    // R6: low-level mode 00, flag is emptied
    mode = 2'b00;
    expect_at(1, 0, 0, "R6 flag dropped in low mode");
    step(3);
    pin = 1'b0;
    expect_at(1, 0, 0, "R6 request not yet");
    expect_at(2, 1, 0, "R6 low level requests");
    step(4);
    en = 1'b0;
    expect_at(0, 0, 0, "R6 request gated by enable");
    step(1);
    en = 1'b1;
    pin = 1'b1;
    expect_at(1, 1, 0, "R6 request held through sync");
    expect_at(2, 0, 0, "R6 request released");
    step(4);

    step(3);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", sbq.size());
    end
    finish_run();
  end

endmodule